// File: doc/BRIEF.md
# Inter-Processor Interrupt Destination Resolver

This block turns an inter-processor interrupt command into a set of target agents and the single action they must take. The command is held in two 32-bit words. The high word carries the destination identifier. A write to the low word carries the vector, the delivery mode, the addressing mode, the level and trigger bits and a shorthand, and that write starts the send. One clock edge later the block presents a one-cycle result strobe. With it come the resolved agent bitmask, a one-hot pick of a single agent for lowest-priority delivery, and one action flag.

A parameter sets the number of agents. Each agent supplies a presence bit and a physical identifier on input ports. The block keeps a logical destination byte and a destination-format model for each agent, and software loads these through a small configuration port. Logical addressing matches either flat bit masks or cluster nibbles, depending on each agent's model. Shorthands bypass the destination field entirely. An INIT command sent with level low and trigger high is treated as a deassert. It delivers nothing and makes each selected agent latch its physical identifier as its arbitration identifier, which is shown on an output bus.

Top module: `ipi_dest_resolver`

## Requirements
- R1: A write to the low command word starts a send. On the next clock edge `dlv_valid` pulses for exactly one cycle, and `dlv_vector` shows low-word bits 7:0. The other low-word fields are: mode in bits 10:8, logical addressing in bit 11, level in bit 14, trigger in bit 15 and shorthand in bits 19:18. The destination is taken from high-word bits 31:24 as last written. Outside the pulse, every result output is zero.
- R2: Shorthand 1 selects only the agent at `sender_idx`. Shorthand 2 selects every agent. Shorthand 3 selects every agent except the sender. Shorthand 0 uses destination matching.
- R3: In physical addressing (bit 11 = 0), destination 0xFF selects every agent. Any other destination selects the agents whose physical identifier equals it.
- R4: In logical addressing, an agent with model 0xF matches when the destination ANDed with its logical byte is non-zero.
- R5: In logical addressing, an agent with model 0x0 matches when the upper nibbles of the destination and its logical byte are equal and the lower nibbles share a set bit. An agent with any other model never matches in logical addressing.
- R6: Mode codes raise these flags: 0 raises `act_fixed`, 1 raises `act_lowpri`, 2 raises `act_smi`, 4 raises `act_nmi`, 5 raises `act_init`, 6 raises `act_startup` and 7 raises `act_extint`. Code 3 raises no flag and gives a zero mask. At most one flag is high at a time.
- R7: In mode 1, `lowpri_sel` is one-hot on the lowest-index agent in the mask, and `dlv_mask` still shows the full set. In all other modes `lowpri_sel` is zero.
- R8: Mode 5 with level 0 and trigger 1 raises only `act_init_deassert`. The arbitration identifier of each selected agent takes that agent's physical identifier at the same edge. Arbitration identifiers change at no other time.
- R9: Reset sets every model to 0xF, every logical byte to 0x00, every arbitration identifier to 0, and every result output to zero.
- R10: Agents whose presence bit is clear are removed from the mask. If the mask is empty, no action flag is raised.
- R11: With `cfg_logical_we`, agent `cfg_idx` loads `cfg_wdata` as its logical byte. With `cfg_model_we`, it loads `cfg_wdata[3:0]` as its model. Each field is written independently of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_lo_we | input | 1 | Write strobe for the low command word; starts a send |
| cmd_lo_wdata | input | 32 | Low command word |
| cmd_hi_we | input | 1 | Write strobe for the high command word |
| cmd_hi_wdata | input | 32 | High command word (destination in bits 31:24) |
| sender_idx | input | IDX_W | Index of the sending agent |
| agent_present | input | N_AGENTS | Presence bit per agent |
| agent_phys_id | input | 8*N_AGENTS | Physical identifier per agent, agent i in bits 8i+7:8i |
| cfg_idx | input | IDX_W | Agent addressed by a configuration write |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_logical_we | input | 1 | Load logical byte of agent `cfg_idx` |
| cfg_model_we | input | 1 | Load format model of agent `cfg_idx` |
| dlv_valid | output | 1 | One-cycle result strobe |
| dlv_vector | output | 8 | Vector of the resolved command |
| dlv_mask | output | N_AGENTS | Resolved agent bitmask |
| lowpri_sel | output | N_AGENTS | One-hot lowest-priority pick |
| act_fixed | output | 1 | Fixed delivery |
| act_lowpri | output | 1 | Lowest-priority delivery |
| act_smi | output | 1 | System-management interrupt |
| act_nmi | output | 1 | Non-maskable interrupt |
| act_init | output | 1 | INIT assert |
| act_startup | output | 1 | Startup delivery |
| act_extint | output | 1 | External interrupt delivery |
| act_init_deassert | output | 1 | INIT deassert (arbitration identifier copy) |
| arb_id | output | 8*N_AGENTS | Arbitration identifier per agent |

## Verification
A wrong stored logical byte or model in an agent shows up only on the first logical-mode send after it. That send is one cycle after the low-word write, where the agent appears in or drops out of `dlv_mask` against the expected set. A wrong arbitration identifier shows at the edge of a deassert, or as a change on `arb_id` with no deassert, so the bench compares the whole bus after every send. Decode or shorthand faults show on the very next strobe as a wrong flag, a wrong mask, or a `lowpri_sel` that does not sit on the lowest set bit of the mask.

// File: rtl/ipi_res_pkg.sv
package ipi_res_pkg;

  localparam int ID_W    = 8;
  localparam int MODEL_W = 4;

  localparam logic [MODEL_W-1:0] MODEL_FLAT    = 4'hF;
  localparam logic [MODEL_W-1:0] MODEL_CLUSTER = 4'h0;
  localparam logic [ID_W-1:0]    DEST_BCAST    = 8'hFF;

  typedef enum logic [2:0] {
    DM_FIXED   = 3'd0,
    DM_LOWPRI  = 3'd1,
    DM_SMI     = 3'd2,
    DM_RSV     = 3'd3,
    DM_NMI     = 3'd4,
    DM_INIT    = 3'd5,
    DM_STARTUP = 3'd6,
    DM_EXTINT  = 3'd7
  } dmode_e;

  typedef enum logic [1:0] {
    SH_DEST   = 2'd0,
    SH_SELF   = 2'd1,
    SH_ALL    = 2'd2,
    SH_OTHERS = 2'd3
  } shorthand_e;

  typedef struct packed {
    logic [7:0] vector;
    dmode_e     mode;
    logic       logical;
    logic       level;
    logic       trigger;
    shorthand_e shorthand;
  } cmd_t;

  typedef struct packed {
    logic fixed;
    logic lowpri;
    logic smi;
    logic nmi;
    logic init;
    logic startup;
    logic extint;
    logic init_deassert;
  } act_t;

  function automatic cmd_t unpack_cmd(input logic [31:0] w);
    cmd_t c;
    c.vector    = w[7:0];
    c.mode      = dmode_e'(w[10:8]);
    c.logical   = w[11];
    c.level     = w[14];
    c.trigger   = w[15];
    c.shorthand = shorthand_e'(w[19:18]);
    return c;
  endfunction

endpackage

// File: rtl/agent_match.sv
module agent_match
  import ipi_res_pkg::*;
(
  input  logic [ID_W-1:0]    dest,
  input  logic               logical,
  input  logic [ID_W-1:0]    phys_id,
  input  logic [ID_W-1:0]    log_byte,
  input  logic [MODEL_W-1:0] model,
  output logic               hit
);

  logic phys_hit;
  logic flat_hit;
  logic clus_hit;

  always_comb begin
    phys_hit = (dest == DEST_BCAST) || (dest == phys_id);
    flat_hit = (model == MODEL_FLAT) && (|(dest & log_byte));
    clus_hit = (model == MODEL_CLUSTER)
               && (dest[7:4] == log_byte[7:4])
               && (|(dest[3:0] & log_byte[3:0]));
    hit      = logical ? (flat_hit || clus_hit) : phys_hit;
  end

endmodule

// File: rtl/dest_select.sv
module dest_select
  import ipi_res_pkg::*;
#(
  parameter  int N_AGENTS = 8,
  localparam int IDX_W    = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
  input  logic [ID_W-1:0]            dest,
  input  logic                       logical,
  input  shorthand_e                 shorthand,
  input  logic [IDX_W-1:0]           sender_idx,
  input  logic [N_AGENTS-1:0]        present,
  input  logic [N_AGENTS*ID_W-1:0]   phys_ids,
  input  logic [N_AGENTS*ID_W-1:0]   log_bytes,
  input  logic [N_AGENTS*MODEL_W-1:0] models,
  output logic [N_AGENTS-1:0]        sel
);

  logic [N_AGENTS-1:0] match_vec;
  logic [N_AGENTS-1:0] self_vec;
  logic [N_AGENTS-1:0] raw_sel;

  for (genvar g = 0; g < N_AGENTS; g++) begin : g_agent
    agent_match u_match (
      .dest     (dest),
      .logical  (logical),
      .phys_id  (phys_ids[g*ID_W +: ID_W]),
      .log_byte (log_bytes[g*ID_W +: ID_W]),
      .model    (models[g*MODEL_W +: MODEL_W]),
      .hit      (match_vec[g])
    );
  end

  always_comb begin
    self_vec = '0;
    self_vec[sender_idx] = 1'b1;
    unique case (shorthand)
      SH_DEST:   raw_sel = match_vec;
      SH_SELF:   raw_sel = self_vec;
      SH_ALL:    raw_sel = '1;
      SH_OTHERS: raw_sel = ~self_vec;
      default:   raw_sel = '0;
    endcase
    sel = raw_sel & present;
  end

endmodule

// File: rtl/low_pick.sv
module low_pick #(
  parameter int N = 8
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);

  always_comb begin
    grant = req & (~req + N'(1));
  end

endmodule

// File: rtl/agent_cfg.sv
module agent_cfg
  import ipi_res_pkg::*;
#(
  parameter  int N_AGENTS = 8,
  localparam int IDX_W    = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [IDX_W-1:0]            cfg_idx,
  input  logic [7:0]                  cfg_wdata,
  input  logic                        cfg_logical_we,
  input  logic                        cfg_model_we,
  input  logic [N_AGENTS-1:0]         arb_load,
  input  logic [N_AGENTS*ID_W-1:0]    phys_ids,
  output logic [N_AGENTS*ID_W-1:0]    log_bytes,
  output logic [N_AGENTS*MODEL_W-1:0] models,
  output logic [N_AGENTS*ID_W-1:0]    arb_ids
);

  for (genvar g = 0; g < N_AGENTS; g++) begin : g_reg
    logic [ID_W-1:0]    log_q,   log_n;
    logic [MODEL_W-1:0] model_q, model_n;
    logic [ID_W-1:0]    arb_q,   arb_n;
    logic               hit_idx;

    always_comb begin
      hit_idx = (cfg_idx == IDX_W'(g));
      log_n   = log_q;
      model_n = model_q;
      arb_n   = arb_q;
      if (cfg_logical_we && hit_idx) log_n   = cfg_wdata;
      if (cfg_model_we && hit_idx)   model_n = cfg_wdata[MODEL_W-1:0];
      if (arb_load[g])               arb_n   = phys_ids[g*ID_W +: ID_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        log_q   <= '0;
        model_q <= MODEL_FLAT;
        arb_q   <= '0;
      end else begin
        log_q   <= log_n;
        model_q <= model_n;
        arb_q   <= arb_n;
      end
    end

    assign log_bytes[g*ID_W +: ID_W]     = log_q;
    assign models[g*MODEL_W +: MODEL_W]  = model_q;
    assign arb_ids[g*ID_W +: ID_W]       = arb_q;
  end

endmodule

// File: rtl/ipi_dest_resolver.sv
module ipi_dest_resolver
  import ipi_res_pkg::*;
#(
  parameter  int N_AGENTS = 8,
  localparam int IDX_W    = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_lo_we,
  input  logic [31:0]              cmd_lo_wdata,
  input  logic                     cmd_hi_we,
  input  logic [31:0]              cmd_hi_wdata,
  input  logic [IDX_W-1:0]         sender_idx,
  input  logic [N_AGENTS-1:0]      agent_present,
  input  logic [N_AGENTS*8-1:0]    agent_phys_id,
  input  logic [IDX_W-1:0]         cfg_idx,
  input  logic [7:0]               cfg_wdata,
  input  logic                     cfg_logical_we,
  input  logic                     cfg_model_we,
  output logic                     dlv_valid,
  output logic [7:0]               dlv_vector,
  output logic [N_AGENTS-1:0]      dlv_mask,
  output logic [N_AGENTS-1:0]      lowpri_sel,
  output logic                     act_fixed,
  output logic                     act_lowpri,
  output logic                     act_smi,
  output logic                     act_nmi,
  output logic                     act_init,
  output logic                     act_startup,
  output logic                     act_extint,
  output logic                     act_init_deassert,
  output logic [N_AGENTS*8-1:0]    arb_id
);

  // reset: asserted asynchronously, released through two flops
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  // high command word
  logic [ID_W-1:0] dest_q, dest_n;
  always_comb begin
    dest_n = dest_q;
    if (cmd_hi_we) dest_n = cmd_hi_wdata[31:24];
  end
  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) dest_q <= '0;
    else             dest_q <= dest_n;
  end

  cmd_t cmd;
  assign cmd = unpack_cmd(cmd_lo_wdata);

  logic [N_AGENTS*ID_W-1:0]    log_bytes;
  logic [N_AGENTS*MODEL_W-1:0] models;
  logic [N_AGENTS-1:0]         sel;
  logic [N_AGENTS-1:0]         low_grant;
  logic [N_AGENTS-1:0]         arb_load;

  dest_select #(.N_AGENTS(N_AGENTS)) u_sel (
    .dest       (dest_q),
    .logical    (cmd.logical),
    .shorthand  (cmd.shorthand),
    .sender_idx (sender_idx),
    .present    (agent_present),
    .phys_ids   (agent_phys_id),
    .log_bytes  (log_bytes),
    .models     (models),
    .sel        (sel)
  );

  low_pick #(.N(N_AGENTS)) u_low (
    .req   (sel),
    .grant (low_grant)
  );

  // decode of action
  logic                is_deassert;
  logic                any_sel;
  act_t                act_n, act_q;
  logic [N_AGENTS-1:0] mask_n, mask_q;
  logic [N_AGENTS-1:0] low_n, low_q;
  logic [7:0]          vec_n, vec_q;
  logic                valid_n, valid_q;

  always_comb begin
    is_deassert = (cmd.mode == DM_INIT) && !cmd.level && cmd.trigger;
    any_sel     = |sel;
    act_n       = '0;
    mask_n      = '0;
    low_n       = '0;
    vec_n       = '0;
    valid_n     = cmd_lo_we;
    if (cmd_lo_we) begin
      vec_n = cmd.vector;
      if (any_sel && cmd.mode != DM_RSV) begin
        mask_n = sel;
        unique case (cmd.mode)
          DM_FIXED:   act_n.fixed   = 1'b1;
          DM_LOWPRI: begin
            act_n.lowpri = 1'b1;
            low_n        = low_grant;
          end
          DM_SMI:     act_n.smi     = 1'b1;
          DM_NMI:     act_n.nmi     = 1'b1;
          DM_INIT: begin
            if (is_deassert) act_n.init_deassert = 1'b1;
            else             act_n.init          = 1'b1;
          end
          DM_STARTUP: act_n.startup = 1'b1;
          DM_EXTINT:  act_n.extint  = 1'b1;
          default:    act_n         = '0;
        endcase
      end
    end
    arb_load = (cmd_lo_we && is_deassert) ? sel : '0;
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      valid_q <= 1'b0;
      vec_q   <= '0;
      mask_q  <= '0;
      low_q   <= '0;
      act_q   <= '0;
    end else begin
      valid_q <= valid_n;
      vec_q   <= vec_n;
      mask_q  <= mask_n;
      low_q   <= low_n;
      act_q   <= act_n;
    end
  end

  agent_cfg #(.N_AGENTS(N_AGENTS)) u_cfg (
    .clk            (clk),
    .rst_n          (rst_sync_q),
    .cfg_idx        (cfg_idx),
    .cfg_wdata      (cfg_wdata),
    .cfg_logical_we (cfg_logical_we),
    .cfg_model_we   (cfg_model_we),
    .arb_load       (arb_load),
    .phys_ids       (agent_phys_id),
    .log_bytes      (log_bytes),
    .models         (models),
    .arb_ids        (arb_id)
  );

  assign dlv_valid         = valid_q;
  assign dlv_vector        = vec_q;
  assign dlv_mask          = mask_q;
  assign lowpri_sel        = low_q;
  assign act_fixed         = act_q.fixed;
  assign act_lowpri        = act_q.lowpri;
  assign act_smi           = act_q.smi;
  assign act_nmi           = act_q.nmi;
  assign act_init          = act_q.init;
  assign act_startup       = act_q.startup;
  assign act_extint        = act_q.extint;
  assign act_init_deassert = act_q.init_deassert;

endmodule

// File: rtl/ipi_dest_resolver_chk.sv
module ipi_dest_resolver_chk #(
  parameter  int N_AGENTS = 8,
  localparam int IDX_W    = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cmd_lo_we,
  input logic [31:0]           cmd_lo_wdata,
  input logic [N_AGENTS-1:0]   agent_present,
  input logic                  dlv_valid,
  input logic [N_AGENTS-1:0]   dlv_mask,
  input logic [N_AGENTS-1:0]   lowpri_sel,
  input logic                  act_fixed,
  input logic                  act_lowpri,
  input logic                  act_smi,
  input logic                  act_nmi,
  input logic                  act_init,
  input logic                  act_startup,
  input logic                  act_extint,
  input logic                  act_init_deassert,
  input logic [N_AGENTS*8-1:0] arb_id
);

  logic [7:0] flags;
  assign flags = {act_fixed, act_lowpri, act_smi, act_nmi,
                  act_init, act_startup, act_extint, act_init_deassert};

  // R1
  strobe_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid |-> $past(cmd_lo_we));

  // R1
  idle_outputs_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dlv_valid |-> (dlv_mask == '0 && lowpri_sel == '0 && flags == '0));

  // R6
  single_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flags));

  // R7
  lowpri_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lowpri_sel) && ((lowpri_sel & ~dlv_mask) == '0));

  // R10
  empty_mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_mask == '0) |-> (flags == '0));

  // R10
  absent_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid |-> ((dlv_mask & ~$past(agent_present)) == '0));

  // R2
  self_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_valid && $past(cmd_lo_wdata[19:18]) == 2'd1) |-> $onehot0(dlv_mask));

  // R8
  arb_only_on_deassert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(arb_id) |-> act_init_deassert);

endmodule

bind ipi_dest_resolver ipi_dest_resolver_chk #(.N_AGENTS(N_AGENTS)) u_chk (
  .clk               (clk),
  .rst_n             (rst_n),
  .cmd_lo_we         (cmd_lo_we),
  .cmd_lo_wdata      (cmd_lo_wdata),
  .agent_present     (agent_present),
  .dlv_valid         (dlv_valid),
  .dlv_mask          (dlv_mask),
  .lowpri_sel        (lowpri_sel),
  .act_fixed         (act_fixed),
  .act_lowpri        (act_lowpri),
  .act_smi           (act_smi),
  .act_nmi           (act_nmi),
  .act_init          (act_init),
  .act_startup       (act_startup),
  .act_extint        (act_extint),
  .act_init_deassert (act_init_deassert),
  .arb_id            (arb_id)
);

// File: tb/ipi_dest_resolver_test.sv
`timescale 1ns/1ps
module ipi_dest_resolver_test;

  localparam int N = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_lo_we = 1'b0;
  logic [31:0]   cmd_lo_wdata = '0;
  logic          cmd_hi_we = 1'b0;
  logic [31:0]   cmd_hi_wdata = '0;
  logic [IW-1:0] sender_idx = '0;
  logic [N-1:0]  agent_present = '1;
  logic [N*8-1:0] agent_phys_id;
  logic [IW-1:0] cfg_idx = '0;
  logic [7:0]    cfg_wdata = '0;
  logic          cfg_logical_we = 1'b0;
  logic          cfg_model_we = 1'b0;
  logic          dlv_valid;
  logic [7:0]    dlv_vector;
  logic [N-1:0]  dlv_mask, lowpri_sel;
  logic          act_fixed, act_lowpri, act_smi, act_nmi;
  logic          act_init, act_startup, act_extint, act_init_deassert;
  logic [N*8-1:0] arb_id;

  always #10 clk = ~clk;

  ipi_dest_resolver #(.N_AGENTS(N)) uut (.*);

  typedef struct packed {
    logic [7:0]   vec;
    logic [N-1:0] mask;
    logic [N-1:0] low;
    logic [7:0]   flags;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    n_tests = 0;
  int    n_fail  = 0;
  bit    done    = 1'b0;

  logic [7:0] m_dest;
  logic [7:0] m_log  [N];
  logic [3:0] m_model[N];
  logic [7:0] m_arb  [N];

  function automatic logic [7:0] pid(int i);
    return 8'h20 + 8'(i);
  endfunction

  initial for (int i = 0; i < N; i++) agent_phys_id[i*8 +: 8] = pid(i);

  task automatic check(string tag, logic [127:0] act, logic [127:0] expv);
    n_tests++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic exp_t predict(logic [31:0] lo);
    exp_t e;
    logic [N-1:0] sel;
    logic [1:0] sh;
    logic [2:0] md;
    logic hit, deas;
    sh = lo[19:18];
    md = lo[10:8];
    sel = '0;
    for (int i = 0; i < N; i++) begin
      hit = 1'b0;
      case (sh)
        2'd0: if (!lo[11]) hit = (m_dest == 8'hFF) || (m_dest == pid(i));
              else if (m_model[i] == 4'hF) hit = |(m_dest & m_log[i]);
              else if (m_model[i] == 4'h0)
                hit = (m_dest[7:4] == m_log[i][7:4]) && |(m_dest[3:0] & m_log[i][3:0]);
        2'd1: hit = (i == int'(sender_idx));
        2'd2: hit = 1'b1;
        default: hit = (i != int'(sender_idx));
      endcase
      sel[i] = hit && agent_present[i];
    end
    e = '0;
    e.vec = lo[7:0];
    deas = (md == 3'd5) && !lo[14] && lo[15];
    if (sel != '0 && md != 3'd3) begin
      e.mask = sel;
      case (md)
        3'd0: e.flags[7] = 1'b1;
        3'd1: begin
          e.flags[6] = 1'b1;
          for (int i = N-1; i >= 0; i--) if (sel[i]) e.low = N'(1) << i;
        end
        3'd2: e.flags[5] = 1'b1;
        3'd4: e.flags[4] = 1'b1;
        3'd5: if (deas) e.flags[0] = 1'b1; else e.flags[3] = 1'b1;
        3'd6: e.flags[2] = 1'b1;
        default: e.flags[1] = 1'b1;
      endcase
    end
    if (deas) for (int i = 0; i < N; i++) if (sel[i]) m_arb[i] = pid(i);
    return e;
  endfunction

  task automatic write_hi(logic [7:0] d);
    @(negedge clk);
    cmd_hi_wdata = {d, 24'h0};
    cmd_hi_we = 1'b1;
    m_dest = d;
    @(negedge clk);
    cmd_hi_we = 1'b0;
  endtask

  task automatic write_cfg(int idx, logic [7:0] d, bit lg, bit md);
    @(negedge clk);
    cfg_idx = IW'(idx);
    cfg_wdata = d;
    cfg_logical_we = lg;
    cfg_model_we = md;
    if (lg) m_log[idx] = d;
    if (md) m_model[idx] = d[3:0];
    @(negedge clk);
    cfg_logical_we = 1'b0;
    cfg_model_we = 1'b0;
  endtask

  // driver: pushes the expected result, then issues the send
  task automatic send(logic [31:0] lo, string tag);
    logic [N*8-1:0] arb_exp;
    @(negedge clk);
    exp_q.push_back(predict(lo));
    tag_q.push_back(tag);
    cmd_lo_wdata = lo;
    cmd_lo_we = 1'b1;
    @(negedge clk);
    cmd_lo_we = 1'b0;
    @(negedge clk);
    check({tag, " result delivered"}, 128'(exp_q.size()), 128'd0);
    for (int i = 0; i < N; i++) arb_exp[i*8 +: 8] = m_arb[i];
    check({tag, " R8 arb ids"}, 128'(arb_id), 128'(arb_exp));
  endtask

  // monitor: pops and compares on each strobe
  always @(negedge clk) begin
    if (rst_n && dlv_valid) begin
      if (exp_q.size() == 0) begin
        check("R1 unexpected strobe", 128'd1, 128'd0);
      end else begin
        exp_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({t, " R1 vector"}, 128'(dlv_vector), 128'(e.vec));
        check({t, " mask"}, 128'(dlv_mask), 128'(e.mask));
        check({t, " R7 lowpri_sel"}, 128'(lowpri_sel), 128'(e.low));
        check({t, " R6 flags"},
              128'({act_fixed, act_lowpri, act_smi, act_nmi, act_init,
                    act_startup, act_extint, act_init_deassert}), 128'(e.flags));
      end
    end
  end

  function automatic logic [31:0] cmd(logic [7:0] v, logic [2:0] md, bit lg,
                                      bit lvl, bit trg, logic [1:0] sh);
    return {12'h0, sh, 2'b00, trg, lvl, 2'b00, lg, md, v};
  endfunction

  initial begin
    for (int i = 0; i < N; i++) begin
      m_log[i] = 8'h00; m_model[i] = 4'hF; m_arb[i] = 8'h00;
    end
    m_dest = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R9 reset state
    check("R9 reset valid", 128'(dlv_valid), 128'd0);
    check("R9 reset mask/flags", 128'({dlv_mask, lowpri_sel, act_fixed, act_nmi}), 128'd0);
    check("R9 reset arb", 128'(arb_id), 128'd0);
    // R9 logical byte 0 matches nothing
    write_hi(8'hFF);
    send(cmd(8'h41, 3'd0, 1, 1, 0, 2'd0), "R9 logical zero");
    // R3 physical single and broadcast
    write_hi(8'h22);
    send(cmd(8'h31, 3'd0, 0, 1, 0, 2'd0), "R3 phys single fixed");
    write_hi(8'hFF);
    send(cmd(8'h32, 3'd4, 0, 1, 0, 2'd0), "R3 phys broadcast nmi");
    write_hi(8'h55);
    send(cmd(8'h33, 3'd0, 0, 1, 0, 2'd0), "R10 no match empty");
    // R11 logical only, model still flat from reset (R4, R9)
    write_cfg(1, 8'h01, 1, 0);
    write_cfg(3, 8'h02, 1, 0);
    write_hi(8'h03);
    send(cmd(8'h34, 3'd2, 1, 1, 0, 2'd0), "R4 flat smi");
    // R5 cluster
    write_cfg(5, 8'h31, 1, 1);
    write_cfg(5, 8'h00, 0, 1);
    write_cfg(6, 8'h42, 1, 0);
    write_cfg(6, 8'h00, 0, 1);
    write_cfg(7, 8'h32, 1, 0);
    write_cfg(7, 8'h00, 0, 1);
    write_cfg(0, 8'h33, 1, 0);
    write_cfg(0, 8'h05, 0, 1);
    write_hi(8'h33);
    send(cmd(8'h35, 3'd0, 1, 1, 0, 2'd0), "R5 cluster fixed");
    // R2 shorthands
    sender_idx = 3'd3;
    send(cmd(8'h36, 3'd6, 0, 1, 0, 2'd1), "R2 self startup");
    agent_present = 8'hEF;
    send(cmd(8'h37, 3'd7, 0, 1, 0, 2'd2), "R2 R10 all extint absent");
    sender_idx = 3'd0;
    send(cmd(8'h38, 3'd1, 0, 1, 0, 2'd3), "R2 R7 others lowpri");
    agent_present = 8'h00;
    send(cmd(8'h39, 3'd0, 0, 1, 0, 2'd2), "R10 none present");
    agent_present = 8'hFF;
    send(cmd(8'h3A, 3'd3, 0, 1, 0, 2'd2), "R6 reserved mode");
    write_hi(8'h25);
    send(cmd(8'h3B, 3'd5, 0, 1, 0, 2'd0), "R6 init assert");
    send(cmd(8'h3C, 3'd1, 0, 1, 0, 2'd0), "R7 lowpri single");
    agent_present = 8'h7D;
    send(cmd(8'h3D, 3'd5, 0, 0, 1, 2'd2), "R8 init deassert");
    agent_present = 8'hFF;
    send(cmd(8'h3E, 3'd5, 0, 0, 0, 2'd1), "R6 init level0 trig0");
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule